// File: doc/BRIEF.md
# Speculative Global Direction History with Checkpoint Recovery

This block keeps one global branch-direction history register per hardware thread. The history is used elsewhere to hash indirect-branch target lookups. Before a prediction is made, the front end asks for a checkpoint. The block returns the selected thread's current history, and that value travels with the branch through the pipeline. Each predicted or resolved direction is shifted into the history through an update port.

Two recovery paths use a checkpoint that comes back from the pipeline. A direction correction rebuilds the history from that checkpoint with the actual outcome appended. It ignores the current register, which may already hold wrong-path bits. A restore, used on a squash or when a checkpoint is released, loads the checkpoint exactly.

The history width must not exceed the internal storage width. A configuration that breaks this rule is rejected when the design is elaborated.

Top module: `ghist_ckpt`

## Requirements
- R1: After an active-low asynchronous reset, every thread's history reads zero.
- R2: In the same cycle as a request, `ckpt_vld_o` equals `ckpt_req_i` and `ckpt_o` equals the present history of thread `ckpt_tid_i`. The checkpoint is taken before any write that the same clock edge makes.
- R3: An update shifts the selected thread's history left by one at the next clock edge. The taken bit enters at bit 0 and the bit shifted out above bit HIST_W-1 is lost.
- R4: A correction sets the selected thread's history to ((checkpoint << 1) + taken) masked to HIST_W bits. The value held before the correction has no effect on the result.
- R5: A restore sets the selected thread's history exactly to the supplied checkpoint.
- R6: A thread that no operation names in a cycle keeps its history unchanged.
- R7: When several operations name the same thread in one cycle, a restore wins over a correction, and a correction wins over an update.
- R8: `hist_o` shows the present history of thread `hist_tid_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ckpt_req_i | input | 1 | Checkpoint request |
| ckpt_tid_i | input | TID_W | Thread whose history is checkpointed |
| ckpt_vld_o | output | 1 | Checkpoint response valid |
| ckpt_o | output | HIST_W | Checkpoint value |
| upd_vld_i | input | 1 | Direction update valid |
| upd_tid_i | input | TID_W | Thread to update |
| upd_taken_i | input | 1 | Direction shifted in |
| fix_vld_i | input | 1 | Direction correction valid |
| fix_tid_i | input | TID_W | Thread to correct |
| fix_ckpt_i | input | HIST_W | Checkpoint carried by the mispredicted branch |
| fix_taken_i | input | 1 | Actual outcome |
| rcv_vld_i | input | 1 | Restore valid |
| rcv_tid_i | input | TID_W | Thread to restore |
| rcv_ckpt_i | input | HIST_W | Checkpoint to load |
| hist_tid_i | input | TID_W | Thread shown on hist_o |
| hist_o | output | HIST_W | Current history of the selected thread |

## Verification
The update, correction and restore ports can all name the same thread in one clock. A checkpoint read can also fall on the same cycle as a write to that thread. The bench makes these collisions both in directed cycles and in a long run with random thread IDs, where the three write ports share a small thread pool. Each cycle, a behavioural model applies the priority and predicts the outcome. It also expects the checkpoint to show the value from before the edge, and the bench compares both outputs against these predictions.

// File: rtl/ghist_pkg.sv
package ghist_pkg;
  typedef enum logic [1:0] {
    OP_KEEP  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_FIX   = 2'd2,
    OP_LOAD  = 2'd3
  } hist_op_e;
endpackage

// File: rtl/ghist_decode.sv
module ghist_decode
  import ghist_pkg::*;
#(
  parameter int TID_W  = 2,
  parameter int THREAD = 0
) (
  input  logic             upd_vld_i,
  input  logic [TID_W-1:0] upd_tid_i,
  input  logic             fix_vld_i,
  input  logic [TID_W-1:0] fix_tid_i,
  input  logic             rcv_vld_i,
  input  logic [TID_W-1:0] rcv_tid_i,
  output hist_op_e         op_o
);
  localparam logic [TID_W-1:0] MY_TID = TID_W'(THREAD);

  logic upd_hit, fix_hit, rcv_hit;

  assign upd_hit = upd_vld_i && (upd_tid_i == MY_TID);
  assign fix_hit = fix_vld_i && (fix_tid_i == MY_TID);
  assign rcv_hit = rcv_vld_i && (rcv_tid_i == MY_TID);

  // restore > correction > update (R7)
  always_comb begin
    if (rcv_hit)      op_o = OP_LOAD;
    else if (fix_hit) op_o = OP_FIX;
    else if (upd_hit) op_o = OP_SHIFT;
    else              op_o = OP_KEEP;
  end
endmodule

// File: rtl/ghist_reg.sv
module ghist_reg
  import ghist_pkg::*;
#(
  parameter int HIST_W  = 16,
  parameter int STORE_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  hist_op_e          op_i,
  input  logic              upd_taken_i,
  input  logic [HIST_W-1:0] fix_ckpt_i,
  input  logic              fix_taken_i,
  input  logic [HIST_W-1:0] rcv_ckpt_i,
  output logic [HIST_W-1:0] q_o
);
  localparam logic [STORE_W-1:0] MASK = STORE_W'((64'd1 << HIST_W) - 64'd1);

  logic [STORE_W-1:0] q_wide, d_wide;

  always_comb begin
    unique case (op_i)
      OP_SHIFT: d_wide = ((q_wide << 1) | STORE_W'(upd_taken_i)) & MASK;
      OP_FIX:   d_wide = ((STORE_W'(fix_ckpt_i) << 1) + STORE_W'(fix_taken_i)) & MASK;
      OP_LOAD:  d_wide = STORE_W'(rcv_ckpt_i) & MASK;
      default:  d_wide = q_wide;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_wide <= '0;
    else         q_wide <= d_wide;
  end

  assign q_o = q_wide[HIST_W-1:0];

  assert_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHIFT) |=> (q_o[HIST_W-1:1] == $past(q_o[HIST_W-2:0])) && (q_o[0] == $past(upd_taken_i)));

  assert_fix_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_FIX) |=> (q_o[HIST_W-1:1] == $past(fix_ckpt_i[HIST_W-2:0])) && (q_o[0] == $past(fix_taken_i)));

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> (q_o == $past(rcv_ckpt_i)));

  assert_upper_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_wide & ~MASK) == '0);
endmodule

// File: rtl/ghist_ckpt.sv
module ghist_ckpt
  import ghist_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int HIST_W      = 16,
  parameter int STORE_W     = 32,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ckpt_req_i,
  input  logic [TID_W-1:0]  ckpt_tid_i,
  output logic              ckpt_vld_o,
  output logic [HIST_W-1:0] ckpt_o,
  input  logic              upd_vld_i,
  input  logic [TID_W-1:0]  upd_tid_i,
  input  logic              upd_taken_i,
  input  logic              fix_vld_i,
  input  logic [TID_W-1:0]  fix_tid_i,
  input  logic [HIST_W-1:0] fix_ckpt_i,
  input  logic              fix_taken_i,
  input  logic              rcv_vld_i,
  input  logic [TID_W-1:0]  rcv_tid_i,
  input  logic [HIST_W-1:0] rcv_ckpt_i,
  input  logic [TID_W-1:0]  hist_tid_i,
  output logic [HIST_W-1:0] hist_o
);
  if (HIST_W > STORE_W || HIST_W < 2) begin : g_bad_cfg
    $error("ghist_ckpt: HIST_W must be in 2..STORE_W");
  end

  logic [HIST_W-1:0] hist_q [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    hist_op_e op;

    ghist_decode #(.TID_W(TID_W), .THREAD(t)) u_dec (
      .upd_vld_i (upd_vld_i),
      .upd_tid_i (upd_tid_i),
      .fix_vld_i (fix_vld_i),
      .fix_tid_i (fix_tid_i),
      .rcv_vld_i (rcv_vld_i),
      .rcv_tid_i (rcv_tid_i),
      .op_o      (op)
    );

    ghist_reg #(.HIST_W(HIST_W), .STORE_W(STORE_W)) u_reg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .op_i        (op),
      .upd_taken_i (upd_taken_i),
      .fix_ckpt_i  (fix_ckpt_i),
      .fix_taken_i (fix_taken_i),
      .rcv_ckpt_i  (rcv_ckpt_i),
      .q_o         (hist_q[t])
    );

    assert_idle_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(upd_vld_i && upd_tid_i == TID_W'(t)) && !(fix_vld_i && fix_tid_i == TID_W'(t)) &&
      !(rcv_vld_i && rcv_tid_i == TID_W'(t)) |=> $stable(hist_q[t]));

    assert_rcv_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rcv_vld_i && rcv_tid_i == TID_W'(t) && fix_vld_i && fix_tid_i == TID_W'(t))
      |=> hist_q[t] == $past(rcv_ckpt_i));

    assert_fix_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(rcv_vld_i && rcv_tid_i == TID_W'(t)) && fix_vld_i && fix_tid_i == TID_W'(t) &&
       upd_vld_i && upd_tid_i == TID_W'(t))
      |=> hist_q[t][0] == $past(fix_taken_i));
  end

  assign ckpt_vld_o = ckpt_req_i;
  assign ckpt_o     = hist_q[ckpt_tid_i];
  assign hist_o     = hist_q[hist_tid_i];

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> hist_o == '0);
endmodule

// File: tb/tb_ghist_ckpt.sv
`timescale 1ns/1ps
module tb_ghist_ckpt;
  localparam int NT = 4;
  localparam int HW = 16;
  localparam int TW = 2;
  localparam int MOD = 1 << HW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ckpt_req_i = 0, upd_vld_i = 0, upd_taken_i = 0, fix_vld_i = 0, fix_taken_i = 0, rcv_vld_i = 0;
  logic [TW-1:0] ckpt_tid_i = 0, upd_tid_i = 0, fix_tid_i = 0, rcv_tid_i = 0, hist_tid_i = 0;
  logic [HW-1:0] fix_ckpt_i = 0, rcv_ckpt_i = 0;
  logic ckpt_vld_o;
  logic [HW-1:0] ckpt_o, hist_o;

  always #4 clk_i = ~clk_i;

  ghist_ckpt #(.NUM_THREADS(NT), .HIST_W(HW), .STORE_W(32)) dut (.*);

  int model [NT];
  string tagof [NT];
  int n_cmp = 0, n_bad = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // outputs are sampled 1 ns after the inputs change, away from the clock edge
  task automatic compare_now();
    #1;
    chk({"R8/", tagof[hist_tid_i]}, int'(hist_o), model[hist_tid_i]);
    chk("R2 ckpt value", int'(ckpt_o), model[ckpt_tid_i]);
    chk("R2 ckpt valid", int'(ckpt_vld_o), int'(ckpt_req_i));
  endtask

  task automatic advance_model();
    for (int t = 0; t < NT; t++) begin
      if (rcv_vld_i && rcv_tid_i == t) begin
        model[t] = int'(rcv_ckpt_i); tagof[t] = "R5/R7";
      end else if (fix_vld_i && fix_tid_i == t) begin
        model[t] = (int'(fix_ckpt_i) * 2 + int'(fix_taken_i)) % MOD; tagof[t] = "R4/R7";
      end else if (upd_vld_i && upd_tid_i == t) begin
        model[t] = (model[t] * 2 + int'(upd_taken_i)) % MOD; tagof[t] = "R3";
      end else begin
        tagof[t] = (tagof[t] == "R1") ? "R1" : "R6";
      end
    end
  endtask

  // drive at negedge, compare, let the posedge update, advance model
  task automatic cycle();
    compare_now();
    @(posedge clk_i);
    advance_model();
    @(negedge clk_i);
  endtask

  task automatic idle();
    upd_vld_i = 0; fix_vld_i = 0; rcv_vld_i = 0; ckpt_req_i = 0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int t = 0; t < NT; t++) begin model[t] = 0; tagof[t] = "R1"; end
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1: every thread reads zero
    for (int t = 0; t < NT; t++) begin
      hist_tid_i = TW'(t); ckpt_tid_i = TW'(t); cycle();
    end

    // R3: shift in 20 bits on thread 1, MSB falls off
    hist_tid_i = 1; ckpt_tid_i = 1;
    for (int i = 0; i < 20; i++) begin
      upd_vld_i = 1; upd_tid_i = 1; upd_taken_i = (i % 3 != 0); ckpt_req_i = 1;
      cycle();
    end
    idle(); cycle();

    // R4: correction ignores polluted current value of thread 1
    fix_vld_i = 1; fix_tid_i = 1; fix_ckpt_i = 16'h8001; fix_taken_i = 1; cycle();
    idle(); cycle();
    fix_vld_i = 1; fix_tid_i = 1; fix_ckpt_i = 16'h7FFF; fix_taken_i = 0; cycle();
    idle(); cycle();

    // R5: restore thread 2
    hist_tid_i = 2;
    rcv_vld_i = 1; rcv_tid_i = 2; rcv_ckpt_i = 16'hBEEF; cycle();
    idle(); cycle();

    // R7: all three on thread 3, then correction+update
    hist_tid_i = 3; ckpt_tid_i = 3;
    upd_vld_i = 1; upd_tid_i = 3; upd_taken_i = 1;
    fix_vld_i = 1; fix_tid_i = 3; fix_ckpt_i = 16'h1234; fix_taken_i = 1;
    rcv_vld_i = 1; rcv_tid_i = 3; rcv_ckpt_i = 16'hA5A5; ckpt_req_i = 1;
    cycle();
    rcv_vld_i = 0; cycle();
    idle(); cycle();

    // R6: ops on thread 0 leave thread 2 alone
    hist_tid_i = 2;
    upd_vld_i = 1; upd_tid_i = 0; upd_taken_i = 1;
    fix_vld_i = 1; fix_tid_i = 1; fix_ckpt_i = 16'h0F0F; fix_taken_i = 0;
    cycle();
    idle(); cycle();

    // random collisions across all ports
    for (int i = 0; i < 4000; i++) begin
      ckpt_req_i = 1'($urandom); ckpt_tid_i = TW'($urandom); hist_tid_i = TW'($urandom);
      upd_vld_i = ($urandom % 4) != 0; upd_tid_i = TW'($urandom); upd_taken_i = 1'($urandom);
      fix_vld_i = ($urandom % 3) == 0; fix_tid_i = TW'($urandom);
      fix_ckpt_i = HW'($urandom); fix_taken_i = 1'($urandom);
      rcv_vld_i = ($urandom % 4) == 0; rcv_tid_i = TW'($urandom); rcv_ckpt_i = HW'($urandom);
      cycle();
    end
    idle();
    for (int t = 0; t < NT; t++) begin hist_tid_i = TW'(t); cycle(); end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule